// File: doc/BRIEF.md
# Link State Transition History Buffer

This block keeps a short debug history of a link training state machine. It watches three live codes: the training state, the link rate index and the low-power substate. Whenever recording is on and the state code changes, it stores one packed word that holds all three codes. The words go into a small circular store.

A register-style read strobe removes words from the store, oldest first. Once the reader has caught up with the writer, another read returns the newest word again. Software therefore sees two equal state codes in a row. Because the block only stores on a change, two equal codes mean that no new history is present.

The read position survives between bursts of reads. After the link moves on, reading resumes where it stopped. A rising edge of the record enable starts a fresh history.

Top module: `lsh_buffer`

## Requirements
- R1: After reset `rd_data` is zero. It changes only in the cycle after a read strobe and then holds until the next strobe.
- R2: With default widths, a word carries the state code in bits [5:0], the rate index in bits [8:6] (0 is the slowest speed) and the substate in bits [10:9] (1 and 2 mark the two deeper sleep levels of the L1 idle state). The rate and substate are the values present in the capture cycle.
- R3: While recording, a word is stored only in a cycle whose state code differs from the last stored state code. A change of rate or substate alone stores nothing.
- R4: In the first cycle that recording is on, both positions are cleared and the current live codes are stored as the first word.
- R5: A strobe in cycle N presents, in cycle N+1, the oldest unread word and consumes it. Words come out in capture order.
- R6: A strobe with no unread word returns the most recently stored word again.
- R7: The read position persists. Words captured after a partial or full drain are read next, without any repeat of words already consumed.
- R8: With DEPTH unread words stored, a new capture overwrites the oldest one. The reader then receives the DEPTH newest words.
- R9: While recording is off, nothing is stored, and words already stored can still be read.
- R10: Turning recording on again discards all unread words from the previous session.
- R11: If nothing has been stored since reset, a read returns the live input codes, packed as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_en | input | 1 | Recording enable; a rising level starts a new session |
| link_state | input | STATE_W | Live training state code |
| link_rate | input | RATE_W | Live rate index |
| link_sub | input | SUB_W | Live low-power substate code |
| rd_stb | input | 1 | Single-cycle read strobe |
| rd_data | output | STATE_W+RATE_W+SUB_W | Packed word from the last read |

## Verification
The embedded assertions watch several properties on every cycle. The unread count never passes the depth. A read of unread data lowers that count by exactly one. Nothing is captured while recording is off, and the write position holds in any cycle with no capture. A restart leaves exactly one word stored. A read on an empty store returns the state code of the last capture, and a read before any capture returns the live codes. Some properties need whole sequences and are shown only by the bench scenarios. These are the capture order, the lap in which the oldest words are overwritten, resumption of reading after new transitions, ignoring rate-only changes, and discarding an old session when recording is turned on again.

// File: rtl/lsh_pkg.sv
package lsh_pkg;
  // Source of a read result
  typedef enum logic [1:0] {
    SRC_UNREAD = 2'd0,
    SRC_REPEAT = 2'd1,
    SRC_LIVE   = 2'd2
  } rd_src_e;
endpackage

// File: rtl/lsh_capture.sv
module lsh_capture #(
  parameter int STATE_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rec_en,
  input  logic [STATE_W-1:0] link_state,
  output logic               wr_fire,
  output logic               restart,
  output logic               has_entry,
  output logic [STATE_W-1:0] last_state
);
  logic               en_q, en_d;
  logic               has_d;
  logic [STATE_W-1:0] last_d;

  always_comb begin
    restart = rec_en & ~en_q;
    wr_fire = rec_en & (restart | ~has_entry | (link_state != last_state));
    en_d    = rec_en;
    has_d   = has_entry | wr_fire;
    last_d  = wr_fire ? link_state : last_state;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      has_entry  <= 1'b0;
      last_state <= '0;
    end else begin
      en_q      <= en_d;
      has_entry <= has_d;
      if (wr_fire) last_state <= last_d;
    end
  end

  // R9
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_en |=> $stable(last_state));
endmodule

// File: rtl/lsh_ring.sv
module lsh_ring #(
  parameter int DEPTH   = 8,
  parameter int ENTRY_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_fire,
  input  logic               restart,
  input  logic               has_entry,
  input  logic [ENTRY_W-1:0] wr_entry,
  input  logic [ENTRY_W-1:0] live_entry,
  input  logic               rd_stb,
  output logic               buf_empty,
  output logic [ENTRY_W-1:0] rd_data
);
  import lsh_pkg::*;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [AW-1:0]      wr_ptr, rd_ptr, wr_n, rd_n, base_wr, base_rd, rd_mid;
  logic [CW-1:0]      fill, fill_n, base_fill, fill_mid;
  logic               rd_pop;
  rd_src_e            src;
  logic [ENTRY_W-1:0] rd_n_data;

  always_comb begin
    buf_empty = (fill == '0);
    if (!buf_empty)     src = SRC_UNREAD;
    else if (has_entry) src = SRC_REPEAT;
    else                src = SRC_LIVE;
    case (src)
      SRC_UNREAD: rd_n_data = mem[rd_ptr];
      SRC_REPEAT: rd_n_data = mem[wr_ptr - AW'(1)];
      default:    rd_n_data = live_entry;
    endcase

    rd_pop    = rd_stb & ~buf_empty & ~restart;
    base_wr   = restart ? '0 : wr_ptr;
    base_rd   = restart ? '0 : rd_ptr;
    base_fill = restart ? '0 : fill;
    rd_mid    = base_rd + AW'(rd_pop);
    fill_mid  = base_fill - CW'(rd_pop);

    wr_n   = base_wr;
    rd_n   = rd_mid;
    fill_n = fill_mid;
    if (wr_fire) begin
      wr_n = base_wr + AW'(1);
      if (fill_mid == FULL) rd_n = rd_mid + AW'(1);
      else                  fill_n = fill_mid + CW'(1);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_fire && (base_wr == AW'(g))) mem[g] <= wr_entry;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      fill    <= '0;
      rd_data <= '0;
    end else begin
      wr_ptr <= wr_n;
      rd_ptr <= rd_n;
      fill   <= fill_n;
      if (rd_stb) rd_data <= rd_n_data;
    end
  end

  // R8
  fill_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FULL);
  // R5
  pop_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !wr_fire && !restart && fill != '0) |=> fill == $past(fill) - CW'(1));
  // R10
  restart_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && wr_fire) |=> (fill == CW'(1) && rd_ptr == '0));
  // R9
  idle_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_fire && !restart) |=> $stable(wr_ptr));
endmodule

// File: rtl/lsh_buffer.sv
module lsh_buffer #(
  parameter int DEPTH   = 8,
  parameter int STATE_W = 6,
  parameter int RATE_W  = 3,
  parameter int SUB_W   = 2,
  localparam int ENTRY_W = STATE_W + RATE_W + SUB_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rec_en,
  input  logic [STATE_W-1:0] link_state,
  input  logic [RATE_W-1:0]  link_rate,
  input  logic [SUB_W-1:0]   link_sub,
  input  logic               rd_stb,
  output logic [ENTRY_W-1:0] rd_data
);
  logic               wr_fire, restart, has_entry, buf_empty;
  logic [STATE_W-1:0] last_state;
  logic [ENTRY_W-1:0] live_entry;

  assign live_entry = {link_sub, link_rate, link_state};

  lsh_capture #(.STATE_W(STATE_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .rec_en(rec_en), .link_state(link_state),
    .wr_fire(wr_fire), .restart(restart), .has_entry(has_entry),
    .last_state(last_state)
  );

  lsh_ring #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_ring (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .restart(restart),
    .has_entry(has_entry), .wr_entry(live_entry), .live_entry(live_entry),
    .rd_stb(rd_stb), .buf_empty(buf_empty), .rd_data(rd_data)
  );

  // R6
  repeat_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && buf_empty && has_entry) |=> rd_data[STATE_W-1:0] == $past(last_state));
  // R11
  live_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !has_entry) |=> rd_data == $past(live_entry));
  // R9
  no_cap_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_en |-> !wr_fire);
endmodule

// File: tb/tb_lsh_buffer.sv
`timescale 1ns/1ps
module tb_lsh_buffer;
  localparam int SW = 6, RW = 3, UW = 2, DEPTH = 8, EW = SW + RW + UW;

  logic          clk = 1'b0;
  logic          rst_n, rec_en, rd_stb;
  logic [SW-1:0] link_state;
  logic [RW-1:0] link_rate;
  logic [UW-1:0] link_sub;
  logic [EW-1:0] rd_data;

  always #2.5 clk = ~clk;

  lsh_buffer #(.DEPTH(DEPTH), .STATE_W(SW), .RATE_W(RW), .SUB_W(UW)) dut (
    .clk(clk), .rst_n(rst_n), .rec_en(rec_en), .link_state(link_state),
    .link_rate(link_rate), .link_sub(link_sub), .rd_stb(rd_stb), .rd_data(rd_data)
  );

  int            n_chk = 0, n_fail = 0;
  logic [EW-1:0] exp_q[$];
  string         tag_q[$];
  logic          take;
  bit            finished = 0;

  function automatic logic [EW-1:0] pk(int s, int r, int u);
    return {UW'(u), RW'(r), SW'(s)};
  endfunction

  task automatic check(string tag, logic [EW-1:0] act, logic [EW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // driver: queue expectation, pulse the strobe
  task automatic rd(logic [EW-1:0] e, string tag);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic st(int s, int r, int u);
    @(negedge clk);
    link_state = SW'(s);
    link_rate  = RW'(r);
    link_sub   = UW'(u);
  endtask

  task automatic set_en(logic v);
    @(negedge clk);
    rec_en = v;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare one result per strobe
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) take <= 1'b0;
    else        take <= rd_stb;
  end

  always @(negedge clk) begin
    if (take) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R5: unexpected read result %h expected none", rd_data);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rec_en = 1'b0; rd_stb = 1'b0;
    link_state = 6'd5; link_rate = 3'd1; link_sub = 2'd0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check("R1 reset value", rd_data, '0);
    // R11: nothing captured yet, live codes returned
    rd(pk(5, 1, 0), "R11 live read");
    idle(2);
    check("R1 hold after read", rd_data, pk(5, 1, 0));

    // R4: enable records current state
    set_en(1'b1);
    idle(3);
    st(5, 2, 0);            // R3: rate-only change, no capture
    st(6'h11, 2, 0);
    st(6'h14, 2, 2);        // R2: deeper sleep substate
    idle(1);
    rd(pk(5, 1, 0),      "R4 first word");
    rd(pk(6'h11, 2, 0),  "R3 second word");
    rd(pk(6'h14, 2, 2),  "R2 packed fields");
    rd(pk(6'h14, 2, 2),  "R6 repeat");
    rd(pk(6'h14, 2, 2),  "R6 repeat again");

    // R7: resume after new transition
    st(3, 0, 0);
    idle(1);
    rd(pk(3, 0, 0), "R7 resume");
    rd(pk(3, 0, 0), "R6 repeat after resume");

    // R8: lap the reader
    for (int i = 0; i < 10; i++) st(6'h20 + i, 1, 0);
    idle(1);
    for (int i = 2; i < 10; i++) rd(pk(6'h20 + i, 1, 0), "R8 newest kept");
    rd(pk(6'h29, 1, 0), "R8 repeat after drain");

    // R9: disabled, drain existing, no new capture
    st(6'h2A, 1, 1);
    st(6'h2B, 1, 0);
    set_en(1'b0);
    st(6'h30, 1, 0);
    st(6'h31, 1, 0);
    idle(1);
    rd(pk(6'h2A, 1, 1), "R9 drain while off");
    rd(pk(6'h2B, 1, 0), "R9 drain while off");
    rd(pk(6'h2B, 1, 0), "R9 no capture while off");

    // R10: re-enable discards old session
    set_en(1'b1);
    st(6'h32, 1, 0);
    set_en(1'b0);
    st(6'h33, 2, 1);
    set_en(1'b1);
    idle(2);
    rd(pk(6'h33, 2, 1), "R10 fresh session");
    rd(pk(6'h33, 2, 1), "R10 old words gone");

    idle(3);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule